// File: doc/BRIEF.md
# Flash Data-Polling Completion Checker

This block sits on the host side of a flash interface and decides when a program or erase operation inside the flash has finished. It is started with a one-cycle pulse carrying the address being written or erased, the bit-7 value that the cell will hold when the operation ends, and an erase flag. It then reads that address over and over through a request/acknowledge read port. Each returned byte is judged on its bit 7, the completion bit, and its bit 5, the device timeout flag.

When bit 7 matches the wanted value, the checker makes one more read and keeps that byte as the settled data. The extra read is needed because bit 7 can settle before the other bits of the same read. When bit 5 shows a device timeout, the checker reads once more before it judges, because the two bits may flip in the same read. A poll limit ends the run with a fail if the device never raises bit 5. The result is held on `done` and `pass` until the next start.

Top module: `dpoll_ctrl`

## Requirements
- R1: After reset, `done`, `pass` and `rd_req` are 0 and `final_data` is 0.
- R2: A `start` pulse while no run is in progress begins a run: `rd_req` is 1 from the next cycle, and every read of the run presents the `start_addr` captured with that pulse on `rd_addr`.
- R3: A poll read whose bit 7 equals the wanted value is followed by exactly one more read. The run then ends with `done`=1 and `pass`=1, and `final_data` holds the byte of that extra read, not the byte of the matching read.
- R4: A poll read whose bit 7 differs from the wanted value and whose bit 5 is 0 is followed by another poll read, and does not end the run (unless R7 applies).
- R5: A poll read whose bit 7 differs and whose bit 5 is 1 is followed by one recheck read. If the recheck's bit 7 matches, the run continues as in R3. Otherwise the run ends with `done`=1 and `pass`=0, with no further read.
- R6: A poll read with bit 5 = 1 and a bit 7 that matches is treated as a match (R3). The timeout flag is not looked at.
- R7: With the limit enabled, the MAX_POLLS-th poll read of a run that shows a bit-7 mismatch with bit 5 = 0 ends the run with `done`=1 and `pass`=0.
- R8: `done` and `pass` hold their values until the next `start`. A `start` while a run is in progress is ignored: the address does not change and the run is not restarted.
- R9: The wanted bit-7 value is `expect_b7` when `op_erase` = 0, and 1 when `op_erase` = 1, because erased cells read as all ones.
- R10: `rd_req` is 0 from the cycle after the read that ends a run, and stays 0 while `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a run |
| start_addr | input | ADDR_W | Address to poll during the run |
| expect_b7 | input | 1 | Bit-7 value that marks completion of a program |
| op_erase | input | 1 | 1 selects an erase run, with a wanted bit 7 of 1 |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | ADDR_W | Address of the current read |
| rd_ack | input | 1 | Completes the current read; `rd_data` is valid in this cycle |
| rd_data | input | 8 | Byte returned by the flash |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with completion seen |
| final_data | output | 8 | Settled byte captured after a pass |

## Verification
The two checks that can land on the same read are the completion match on bit 7 and the timeout flag on bit 5. The bench provokes this by returning one byte with both bits set. It judges the result by the number of reads taken and by the verdict: the run must take the pass path with exactly one extra read, not the recheck path. The bench also returns the timeout flag on a mismatching byte, followed by a matching recheck and then by a mismatching one. These runs are swept across every count of earlier misses up to and beyond the poll limit, over both wanted values and both operation kinds.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;

  typedef enum logic [1:0] {
    PH_POLL  = 2'd0,
    PH_RECHK = 2'd1,
    PH_FINAL = 2'd2
  } phase_e;

  typedef enum logic [2:0] {
    V_AGAIN = 3'd0,
    V_RECHK = 3'd1,
    V_FINAL = 3'd2,
    V_PASS  = 3'd3,
    V_FAIL  = 3'd4
  } verdict_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } state_e;

  // wanted completion bit: erased cells read as one
  function automatic logic want_bit(input logic erase, input logic exp);
    return erase | exp;
  endfunction

  // verdict for one acknowledged read
  function automatic verdict_e judge(input phase_e ph, input logic [7:0] d,
                                     input logic want, input logic at_lim);
    verdict_e v;
    case (ph)
      PH_FINAL: v = V_PASS;
      PH_RECHK: v = (d[7] == want) ? V_FINAL : V_FAIL;
      default: begin
        if (d[7] == want)  v = V_FINAL;
        else if (d[5])     v = V_RECHK;
        else if (at_lim)   v = V_FAIL;
        else               v = V_AGAIN;
      end
    endcase
    return v;
  endfunction

endpackage

// File: rtl/dpoll_decide.sv
module dpoll_decide
  import dpoll_pkg::*;
(
  input  logic       ack,
  input  phase_e     phase,
  input  logic [7:0] data,
  input  logic       want,
  input  logic       at_lim,
  output logic       ev_again,
  output logic       ev_rechk,
  output logic       ev_final,
  output logic       ev_pass,
  output logic       ev_fail
);

  verdict_e v;

  always_comb begin
    v        = judge(phase, data, want, at_lim);
    ev_again = ack && (v == V_AGAIN);
    ev_rechk = ack && (v == V_RECHK);
    ev_final = ack && (v == V_FINAL);
    ev_pass  = ack && (v == V_PASS);
    ev_fail  = ack && (v == V_FAIL);
  end

endmodule

// File: rtl/dpoll_limit.sv
module dpoll_limit #(
  parameter int MAX_POLLS = 1000,
  parameter bit LIMIT_EN  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic at_lim
);

  localparam int CW = $clog2(MAX_POLLS + 1);

  generate
    if (LIMIT_EN) begin : g_lim
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (bump)       cnt <= cnt + 1'b1;
      end

      assign at_lim = (cnt == CW'(MAX_POLLS - 1));

      AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(MAX_POLLS)); // R7
    end else begin : g_nolim
      assign at_lim = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/dpoll_ctrl.sv
module dpoll_ctrl
  import dpoll_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MAX_POLLS = 1000,
  parameter bit LIMIT_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              expect_b7,
  input  logic              op_erase,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [7:0]        rd_data,
  output logic              done,
  output logic              pass,
  output logic [7:0]        final_data
);

  state_e state;
  phase_e phase;
  logic   want;
  logic   pass_q;

  // named events for assertions
  logic take_start;
  logic ev_again, ev_rechk, ev_final, ev_pass, ev_fail;
  logic at_lim;

  assign take_start = start && (state != ST_BUSY);
  assign rd_req     = (state == ST_BUSY);
  assign done       = (state == ST_DONE);
  assign pass       = pass_q;

  dpoll_decide u_decide (
    .ack      (rd_ack && rd_req),
    .phase    (phase),
    .data     (rd_data),
    .want     (want),
    .at_lim   (at_lim),
    .ev_again (ev_again),
    .ev_rechk (ev_rechk),
    .ev_final (ev_final),
    .ev_pass  (ev_pass),
    .ev_fail  (ev_fail)
  );

  dpoll_limit #(.MAX_POLLS(MAX_POLLS), .LIMIT_EN(LIMIT_EN)) u_limit (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (take_start),
    .bump   (ev_again),
    .at_lim (at_lim)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      phase      <= PH_POLL;
      rd_addr    <= '0;
      want       <= 1'b0;
      pass_q     <= 1'b0;
      final_data <= '0;
    end else if (take_start) begin
      state      <= ST_BUSY;
      phase      <= PH_POLL;
      rd_addr    <= start_addr;
      want       <= want_bit(op_erase, expect_b7);
      pass_q     <= 1'b0;
      final_data <= '0;
    end else if (state == ST_BUSY) begin
      if (ev_rechk) phase <= PH_RECHK;
      if (ev_final) phase <= PH_FINAL;
      if (ev_pass) begin
        final_data <= rd_data;
        pass_q     <= 1'b1;
        state      <= ST_DONE;
      end
      if (ev_fail) state <= ST_DONE;
    end
  end

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && $past(rd_req)) |-> $stable(rd_addr)); // R2
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_again, ev_rechk, ev_final, ev_pass, ev_fail})); // R5
  AST_RECHK_READS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rechk |=> rd_req && !done); // R5
  AST_FAIL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |=> done && !pass && !rd_req); // R5
  AST_PASS_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> $past(rd_ack)); // R3
  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req); // R10
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done && $stable(pass) && $stable(final_data)); // R8
  AST_PASS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done); // R8
  AST_MISS_GOES_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ev_again |=> rd_req && !done); // R4

endmodule

// File: tb/dpoll_ctrl_test.sv
module dpoll_ctrl_test;

  localparam int AW   = 16;
  localparam int MAXP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          expect_b7 = 1'b0;
  logic          op_erase = 1'b0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_ack = 1'b0;
  logic [7:0]    rd_data = '0;
  logic          done, pass;
  logic [7:0]    final_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] resp [0:15];

  always #2.5 clk = ~clk;

  dpoll_ctrl #(.ADDR_W(AW), .MAX_POLLS(MAXP), .LIMIT_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .expect_b7(expect_b7), .op_erase(op_erase), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .done(done),
    .pass(pass), .final_data(final_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // expected outcome from the requirements: reads taken, verdict, byte kept
  task automatic predict(input logic w, output int n, output bit ok, output logic [7:0] fb);
    int misses = 0;
    int i = 0;
    n = 0; ok = 0; fb = 8'h00;
    while (i < 14) begin
      if (resp[i][7] == w) begin                    // R3, R6
        fb = resp[i+1]; n = i + 2; ok = 1; return;
      end
      if (resp[i][5] == 1'b1) begin                 // R5
        if (resp[i+1][7] == w) begin
          fb = resp[i+2]; n = i + 3; ok = 1;
        end else begin
          n = i + 2; ok = 0;
        end
        return;
      end
      misses = misses + 1;                          // R4, R7
      i = i + 1;
      if (misses == MAXP) begin
        n = i; ok = 0; return;
      end
    end
  endtask

  task automatic run_case(input int m, input int k, input logic ex, input logic er,
                          input int lat, input int id);
    logic w;
    int p;
    int n_exp; bit ok_exp; logic [7:0] f_exp;
    int idx; int wt; int cyc; bit addr_bad;
    logic [AW-1:0] a;
    logic [7:0] fin;
    w   = er ? 1'b1 : ex;                           // R9
    a   = AW'(16'h1000 + id * 7);
    fin = {id[0], 1'b1, id[5:0]};
    for (int j = 0; j < 16; j++) resp[j] = {~w, 1'b1, 1'b0, 5'(j)};
    p = m;
    case (k)
      0: begin resp[p] = {w, 7'h11}; resp[p+1] = fin; end
      1: begin resp[p] = {~w, 2'b01, 5'h03}; resp[p+1] = {w, 7'h05}; resp[p+2] = fin; end
      2: begin resp[p] = {~w, 2'b01, 5'h03}; resp[p+1] = {~w, 2'b00, 5'h06}; end
      3: begin resp[p] = {w, 2'b01, 5'h0C}; resp[p+1] = fin; end
      default: ;
    endcase
    predict(w, n_exp, ok_exp, f_exp);

    @(negedge clk);
    start = 1'b1; start_addr = a; expect_b7 = ex; op_erase = er;
    @(negedge clk);
    start = 1'b0;
    chk(rd_req == 1'b1, "R2 rd_req after start", rd_req, 1);
    idx = 0; wt = lat; cyc = 0; addr_bad = 0;
    while (!done && cyc < 300) begin
      rd_ack = 1'b0;
      if (rd_req) begin
        if (wt == 0) begin
          if (rd_addr != a) addr_bad = 1;
          rd_ack = 1'b1; rd_data = resp[idx]; idx++; wt = lat;
        end else wt--;
      end
      if (m >= 1 && cyc == 1) begin
        start = 1'b1; start_addr = ~a;              // R8: ignored while busy
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    rd_ack = 1'b0; start = 1'b0;
    chk(!addr_bad, "R2 address held", addr_bad, 0);
    chk(done == 1'b1, "R4 run ends", done, 1);
    chk(idx == n_exp, "R5 read count", idx, n_exp);
    chk(pass == ok_exp, "R3 verdict", pass, ok_exp);
    if (ok_exp) chk(final_data == f_exp, "R3 final byte", final_data, f_exp);
    if (k == 3 && m < MAXP) chk(idx == m + 2, "R6 match beats timeout", idx, m + 2);
    if (k == 4) chk(pass == 1'b0, "R7 poll limit", pass, 0);
    for (int h = 0; h < 2; h++) begin
      @(negedge clk);
      chk(done && pass == ok_exp, "R8 result held", {done, pass}, {1'b1, ok_exp});
      chk(!rd_req, "R10 no request when done", rd_req, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !pass && !rd_req && final_data == 8'h00, "R1 reset state",
        {done, pass, rd_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !rd_req, "R1 idle after reset", {done, rd_req}, 0);
    begin
      int id = 0;
      for (int m = 0; m <= MAXP + 1; m++)
        for (int k = 0; k < 5; k++)
          for (int e = 0; e < 4; e++) begin
            run_case(m, k, e[0], e[1], (m + k + e) % 3, id);
            id++;
          end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule